// File: doc/BRIEF.md
# Two-Phase Interleaved Leading-Edge PWM Generator

This block produces the switching requests for two synchronous buck phases that share one system clock. Each phase owns a digital sawtooth that counts from zero to `PERIOD-1` system cycles and then wraps. The second phase's sawtooth starts half a period away from the first, so the two phases switch in alternation. A digital control word for each phase stands in for the output of the analog error and summing stage.

Modulation is leading-edge. The high-side request of a phase rises in the cycle its sawtooth reaches the threshold `PERIOD - duty`. It falls when the sawtooth wraps, which is that phase's clock edge. The low-side request covers the rest of the period. The control word is taken only at the wrap, so each phase turns on at most once per period. The duty is clamped so that the low side stays on for at least an off-window of `max(PERIOD/10, MIN_LS)` cycles in every period. That off-window serves both as a duty cap of about 90 percent and as a floor on low-side on-time.

A light-load input silences phase A completely while phase B keeps switching. A run input, when low, removes every request. Dead time between the high-side and low-side requests is inserted downstream.

Top module: `ilpwm_dual`

## Requirements
- R1: Each phase sawtooth has a period of exactly `PERIOD` cycles. After reset the phase-A sawtooth is 0 and the phase-B sawtooth is `PERIOD/2`. With equal control words, a rise of `hs_b` follows a rise of `hs_a` by `PERIOD/2` cycles, and consecutive rises of one phase are `PERIOD` cycles apart.
- R2: For a control word `c` with `1 <= c <= PERIOD-OFF`, the high-side request of a phase is high for exactly `c` consecutive cycles per period. It rises when the sawtooth equals `PERIOD-c` and falls on the wrap to 0.
- R3: A control word above `PERIOD-OFF` gives a high time of exactly `PERIOD-OFF` cycles, where `OFF = max(PERIOD/10, MIN_LS)`. With the defaults `PERIOD=40` and `MIN_LS=6`, OFF is 6 and the cap is 34.
- R4: While a phase is enabled, its low-side request is the complement of its high-side request. The two are never high together, and the low side is high for at least OFF cycles per period.
- R5: A control word is captured only at its phase's wrap. A change in the middle of a period does not alter the pulse of that period; it takes effect from the next period.
- R6: While `light_load` is high, `hs_a` and `ls_a` are both low from the next cycle on, and phase B keeps its normal pattern.
- R7: While `run` is low, all four requests are low from the next cycle on. The sawtooths keep counting.
- R8: During reset and in the first cycle after it, all requests are low.
- R9: A control word of 0 keeps the high side low for the whole period, with the low side high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Global enable; low forces all requests low |
| light_load | input | 1 | High turns phase A fully off |
| ctl_a | input | CW | Duty control word for phase A, in cycles |
| ctl_b | input | CW | Duty control word for phase B, in cycles |
| hs_a | output | 1 | High-side request, phase A |
| ls_a | output | 1 | Low-side request, phase A |
| hs_b | output | 1 | High-side request, phase B |
| ls_b | output | 1 | Low-side request, phase B |

## Verification
An input change on `run` or `light_load` shows at the outputs after exactly one clock edge, because each request is a register computed from the sawtooth's next value. A new control word appears only in the period that starts after the next wrap of its phase. The bench's reference model advances once per rising edge from the inputs it has driven. It queues one expected output set per edge, and the monitor pops and compares that set at the following falling edge, so each comparison lines up with the one register stage. The width, period and phase-offset measurements count the falling edges between observed output transitions.

// File: rtl/ilpwm_pkg.sv
package ilpwm_pkg;

    // Low-side window: the larger of a tenth of the period and the floor.
    function automatic int off_window(input int period, input int min_ls);
        int tenth;
        tenth = period / 10;
        return (tenth > min_ls) ? tenth : min_ls;
    endfunction

    // Starting point of the sawtooth for phase idx out of nph phases.
    function automatic int ramp_origin(input int period, input int idx, input int nph);
        return (period * idx) / nph;
    endfunction

endpackage

// File: rtl/ilpwm_ramp.sv
module ilpwm_ramp #(
    parameter int PERIOD = 40,
    parameter int START  = 0,
    localparam int RW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [RW-1:0] ramp_o,
    output logic [RW-1:0] ramp_nx_o,
    output logic          wrap_o
);
    typedef struct packed {
        logic [RW-1:0] count;
    } ramp_state_t;

    ramp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap_o = (st_q.count == RW'(PERIOD - 1));
        if (wrap_o) st_d.count = '0;
        else        st_d.count = st_q.count + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{count: RW'(START)};
        else        st_q <= st_d;
    end

    assign ramp_o    = st_q.count;
    assign ramp_nx_o = st_d.count;

    // R1: the sawtooth returns to zero right after its last step
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (ramp_o == '0));

    a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_o <= RW'(PERIOD - 1));
endmodule

// File: rtl/ilpwm_limit.sv
module ilpwm_limit #(
    parameter int PERIOD = 40,
    parameter int MIN_LS = 6,
    localparam int CW    = $clog2(PERIOD + 1),
    localparam int OFF   = ilpwm_pkg::off_window(PERIOD, MIN_LS),
    localparam int MAXD  = PERIOD - OFF
) (
    input  logic [CW-1:0] ctl_i,
    output logic [CW-1:0] thr_o
);
    logic [CW-1:0] duty;

    always_comb begin
        duty  = (ctl_i > CW'(MAXD)) ? CW'(MAXD) : ctl_i;
        thr_o = CW'(PERIOD) - duty;
    end

    // R3: threshold never leaves less than the off-window for the low side
    always_comb begin
        a_r3_thr_floor: assert (thr_o >= CW'(OFF));
    end
endmodule

// File: rtl/ilpwm_phase.sv
module ilpwm_phase #(
    parameter int PERIOD = 40,
    parameter int MIN_LS = 6,
    localparam int RW    = $clog2(PERIOD),
    localparam int CW    = $clog2(PERIOD + 1),
    localparam int OFF   = ilpwm_pkg::off_window(PERIOD, MIN_LS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic [RW-1:0] ramp_i,
    input  logic [RW-1:0] ramp_nx_i,
    input  logic          wrap_i,
    input  logic [CW-1:0] ctl_i,
    output logic          hs_o,
    output logic          ls_o
);
    typedef struct packed {
        logic [CW-1:0] thr;
        logic          en;
        logic          hs;
        logic          ls;
    } phase_state_t;

    phase_state_t st_d, st_q;
    logic [CW-1:0] thr_lim;

    ilpwm_limit #(.PERIOD(PERIOD), .MIN_LS(MIN_LS)) u_limit (
        .ctl_i (ctl_i),
        .thr_o (thr_lim)
    );

    always_comb begin
        st_d     = st_q;
        st_d.thr = wrap_i ? thr_lim : st_q.thr;
        st_d.en  = enable_i;
        st_d.hs  = enable_i && (CW'(ramp_nx_i) >= st_d.thr);
        st_d.ls  = enable_i && !st_d.hs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{thr: CW'(PERIOD), en: 1'b0, hs: 1'b0, ls: 1'b0};
        else        st_q <= st_d;
    end

    assign hs_o = st_q.hs;
    assign ls_o = st_q.ls;

    // R2: once on, the high side stays on until the sawtooth wraps
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && $past(st_q.en) && $past(st_q.hs) && ramp_i != '0) |-> st_q.hs);

    // R2: the high side falls at the wrap
    a_r2_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hs && wrap_i) |=> !st_q.hs);

    // R4: high side never on inside the low-side window at the period start
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hs |-> (ramp_i >= RW'(OFF)));
endmodule

// File: rtl/ilpwm_dual.sv
module ilpwm_dual #(
    parameter int PERIOD = 40,
    parameter int MIN_LS = 6,
    localparam int NPH   = 2,
    localparam int RW    = $clog2(PERIOD),
    localparam int CW    = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          light_load,
    input  logic [CW-1:0] ctl_a,
    input  logic [CW-1:0] ctl_b,
    output logic          hs_a,
    output logic          ls_a,
    output logic          hs_b,
    output logic          ls_b
);
    logic [CW-1:0] ctl_arr [NPH];
    logic          hs_arr  [NPH];
    logic          ls_arr  [NPH];
    logic          en_arr  [NPH];

    assign ctl_arr[0] = ctl_a;
    assign ctl_arr[1] = ctl_b;

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        logic [RW-1:0] ramp, ramp_nx;
        logic          wrap;

        // phase 0 is the one that the light-load input shuts off
        if (i == 0) begin : g_light
            assign en_arr[i] = run && !light_load;
        end else begin : g_full
            assign en_arr[i] = run;
        end

        ilpwm_ramp #(
            .PERIOD (PERIOD),
            .START  (ilpwm_pkg::ramp_origin(PERIOD, i, NPH))
        ) u_ramp (
            .clk       (clk),
            .rst_n     (rst_n),
            .ramp_o    (ramp),
            .ramp_nx_o (ramp_nx),
            .wrap_o    (wrap)
        );

        ilpwm_phase #(.PERIOD(PERIOD), .MIN_LS(MIN_LS)) u_phase (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable_i  (en_arr[i]),
            .ramp_i    (ramp),
            .ramp_nx_i (ramp_nx),
            .wrap_i    (wrap),
            .ctl_i     (ctl_arr[i]),
            .hs_o      (hs_arr[i]),
            .ls_o      (ls_arr[i])
        );
    end

    assign hs_a = hs_arr[0];
    assign ls_a = ls_arr[0];
    assign hs_b = hs_arr[1];
    assign ls_b = ls_arr[1];

    // R4: the two requests of a phase are never on together
    a_r4_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a && ls_a) && !(hs_b && ls_b));

    // R7: stopping clears every request at the next edge
    a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!hs_a && !ls_a && !hs_b && !ls_b));

    // R6: light load silences phase A at the next edge
    a_r6_light: assert property (@(posedge clk) disable iff (!rst_n)
        light_load |=> (!hs_a && !ls_a));
endmodule

// File: tb/ilpwm_dual_bench.sv
module ilpwm_dual_bench;
    localparam int CLK_NS = 10;
    localparam int P      = 40;
    localparam int MINLS  = 6;
    localparam int OFF    = (P / 10 > MINLS) ? P / 10 : MINLS;
    localparam int CW     = $clog2(P + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic light_load = 1'b0;
    logic [CW-1:0] ctl_a = '0, ctl_b = '0;
    logic hs_a, ls_a, hs_b, ls_b;

    int n_run = 0, n_fail = 0;
    string cur_req = "R8";
    bit finished = 0;

    always #(CLK_NS / 2) clk = ~clk;

    ilpwm_dual #(.PERIOD(P), .MIN_LS(MINLS)) u_ilpwm_dual (
        .clk(clk), .rst_n(rst_n), .run(run), .light_load(light_load),
        .ctl_a(ctl_a), .ctl_b(ctl_b),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    // ---------------- reference model and scoreboard ----------------
    typedef struct packed { logic ha, la, hb, lb; } exp_t;
    exp_t exp_q[$];
    int m_ramp [2];
    int m_thr  [2];

    function automatic int clamp_thr(input int c);
        int d;
        d = (c > P - OFF) ? P - OFF : c;
        return P - d;
    endfunction

    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            m_ramp[0] = 0; m_ramp[1] = P / 2;
            m_thr[0] = P;  m_thr[1] = P;
            e = '0;
        end else begin
            bit en [2];
            bit h  [2];
            en[0] = run && !light_load;
            en[1] = run;
            for (int i = 0; i < 2; i++) begin
                if (m_ramp[i] == P - 1) begin
                    m_ramp[i] = 0;
                    m_thr[i]  = clamp_thr(i == 0 ? int'(ctl_a) : int'(ctl_b));
                end else begin
                    m_ramp[i] = m_ramp[i] + 1;
                end
                h[i] = en[i] && (m_ramp[i] >= m_thr[i]);
            end
            e.ha = h[0]; e.la = en[0] && !h[0];
            e.hb = h[1]; e.lb = en[1] && !h[1];
        end
        exp_q.push_back(e);
    end

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e, a;
            e = exp_q.pop_front();
            a = '{hs_a, ls_a, hs_b, ls_b};
            n_run++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s scoreboard: got hs_a/ls_a/hs_b/ls_b=%b expected %b at %0t",
                         cur_req, a, e, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input int got, input int want, input string what);
        n_run++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, want);
        end
    endtask

    function automatic logic sig(input int which);
        case (which)
            0: return hs_a;
            1: return ls_a;
            2: return hs_b;
            default: return ls_b;
        endcase
    endfunction

    // counts falling edges until a rise on the chosen output
    task automatic wait_rise(input int which, output int n);
        logic p, c;
        n = 0;
        p = sig(which);
        forever begin
            @(negedge clk);
            n++;
            c = sig(which);
            if ((c && !p) || n > 4 * P) break;
            p = c;
        end
    endtask

    // after a rise, counts cycles the output stays high
    task automatic high_len(input int which, output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (!sig(which) || n > 2 * P) break;
            n++;
        end
    endtask

    task automatic count_high(input int which, input int cycles, output int n);
        n = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (sig(which)) n++;
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int n, w;
        repeat (3) @(negedge clk);
        check("R8", int'(hs_a | ls_a | hs_b | ls_b), 0, "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", int'(hs_a | ls_a | hs_b | ls_b), 0, "outputs first cycle after reset");
        run = 1'b1;

        cur_req = "R2";
        ctl_a = CW'(10); ctl_b = CW'(10);
        repeat (2 * P + 2) @(negedge clk);
        wait_rise(0, n); high_len(0, w);
        check("R2", w, 10, "hs_a width for ctl 10");
        wait_rise(2, n); high_len(2, w);
        check("R2", w, 10, "hs_b width for ctl 10");

        cur_req = "R1";
        wait_rise(0, n); wait_rise(0, n);
        check("R1", n, P, "cycles between hs_a rises");
        wait_rise(0, n); wait_rise(2, n);
        check("R1", n, P / 2, "hs_a rise to hs_b rise");

        cur_req = "R3";
        ctl_a = CW'(P); ctl_b = CW'(37);
        repeat (2 * P + 2) @(negedge clk);
        wait_rise(0, n); high_len(0, w);
        check("R3", w, P - OFF, "hs_a width clamped from ctl 40");
        wait_rise(2, n); high_len(2, w);
        check("R3", w, P - OFF, "hs_b width clamped from ctl 37");

        cur_req = "R4";
        wait_rise(1, n); high_len(1, w);
        check("R4", w, OFF, "ls_a width at duty cap");
        count_high(0, P, n); count_high(1, P, w);
        check("R4", n + w, P, "hs_a plus ls_a cycles per period");

        cur_req = "R5";
        ctl_a = CW'(10); ctl_b = CW'(10);
        repeat (2 * P + 2) @(negedge clk);
        wait_rise(0, n);
        ctl_a = CW'(30);
        high_len(0, w);
        check("R5", w, 10, "pulse width unchanged by mid-period write");
        wait_rise(0, n); high_len(0, w);
        check("R5", w, 30, "new width from next period");

        cur_req = "R9";
        ctl_b = '0;
        repeat (2 * P + 2) @(negedge clk);
        count_high(2, 2 * P, n);
        check("R9", n, 0, "hs_b high cycles with ctl 0");
        count_high(3, 2 * P, n);
        check("R9", n, 2 * P, "ls_b high cycles with ctl 0");

        cur_req = "R6";
        ctl_b = CW'(12);
        light_load = 1'b1;
        @(negedge clk);
        count_high(0, 2 * P, n); count_high(1, 2 * P, w);
        check("R6", n + w, 0, "phase A activity under light load");
        wait_rise(2, n); high_len(2, w);
        check("R6", w, 12, "phase B width under light load");
        light_load = 1'b0;
        repeat (P) @(negedge clk);

        cur_req = "R7";
        run = 1'b0;
        @(negedge clk);
        check("R7", int'(hs_a | ls_a | hs_b | ls_b), 0, "outputs one cycle after stop");
        count_high(3, P, n);
        check("R7", n, 0, "ls_b while stopped");
        run = 1'b1;
        repeat (2 * P) @(negedge clk);
        wait_rise(0, n); high_len(0, w);
        check("R7", w, 30, "hs_a width after restart");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule